// File: doc/BRIEF.md
# Memory Read Latency Calibrator

This block sits beside an address generator that issues reads to an external memory. The memory's read delay is not known at build time. After a start pulse, the block waits for the first valid address. It then counts clock cycles until the user side reports that the matching twiddle and data words are back. The count becomes the latency for the rest of the transform. One value serves both the twiddle path and the data path, because both are assumed to return with the same delay.

Each address carries a tag, such as an output address or a pass marker. The tag enters a tapped delay line. Once the latency is known, the tap is set to that latency, so every tag comes out in the same cycle as the word its address fetched.

After calibration, the block expects a returning word in every cycle for which an address was issued. A missing word sets a sticky error flag. If no word returns within the supported maximum, a separate timeout flag is set instead.

Top module: `rd_lat_calibrator`

## Requirements
- R1: After reset, `calibrated`, `latency`, `timeoutErr`, `gapErr` and `tagOutValid` are all zero, and the block stays idle until the first `startPulse`.
- R2: After a start, the first cycle with `addrValid` high is cycle 0. If `dataValid` is first high in cycle L (1 ≤ L ≤ 15), then `latency` equals L from the next cycle on.
- R3: `calibrated` goes high in the cycle after the `dataValid` that ends the measurement. `latency` then holds its value until the next `startPulse`, whatever `dataValid` does.
- R4: If `dataValid` is still low in cycle 15, `timeoutErr` goes high in the next cycle and `calibrated` stays low. A later `dataValid` does not calibrate.
- R5: While calibrated, and also in the cycle that ends the measurement, `tagOutValid`/`tagOut` equal `addrValid`/`tagIn` from exactly `latency` cycles earlier. At all other times `tagOutValid` is low.
- R6: While calibrated, any cycle with `tagOutValid` high and `dataValid` low sets `gapErr`. `gapErr` stays high until the next `startPulse`.
- R7: `startPulse` has priority over everything else. In the next cycle it clears `calibrated`, `latency`, `timeoutErr` and `gapErr`, and it rearms the measurement. `addrValid` in the start cycle is not counted.
- R8: `dataValid` pulses that arrive after a start but before the first `addrValid` are ignored. The measurement still runs from the first address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Clears all results and rearms the measurement |
| addrValid | input | 1 | A read address is being issued this cycle |
| tagIn | input | TAG_W | Tag travelling with the issued address |
| dataValid | input | 1 | User reports that twiddle and data words are back |
| latency | output | 4 | Measured read delay in cycles (0 when unknown) |
| calibrated | output | 1 | Latency is known and the tag delay is in use |
| timeoutErr | output | 1 | No return within 15 cycles of the first address |
| gapErr | output | 1 | Sticky: an expected returning word was missing |
| tagOut | output | TAG_W | Tag aligned with the returning word |
| tagOutValid | output | 1 | `tagOut` carries the tag of a returning word |

## Verification
The bench calibrates every latency from 1 to 15 and pushes each issued tag into a scoreboard along with its due cycle. A delay line tapped one stage off would deliver every tag a cycle early or late, and a comparator off by one at the boundary would give up before a latency of 15. Each run also drops one returning word in the middle of the stream, and the bench checks that the sticky flag rises in exactly the next cycle while the latency stays put. It also checks that a run with no dropped word leaves the flag clear. Separate runs cover a response that never arrives, where a design must flag a timeout at cycle 15 and must not calibrate on a late word. They also cover stray valid pulses before the first address: a design that counted those would measure a wrong, too-short latency.

// File: rtl/lat_cal_pkg.sv
package lat_cal_pkg;
  localparam int MAX_LAT = 15;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);
  localparam int TAPS    = MAX_LAT + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_COUNT = 2'd2,
    ST_RUN   = 2'd3
  } cal_state_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LAT_W-1:0] tapIdx;
    logic             tapEnable;
  } cal_ctl_t;
endpackage

// File: rtl/lat_cal_ctrl.sv
module lat_cal_ctrl
  import lat_cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic             addrValid,
  input  logic             dataValid,
  input  logic             tapValid,
  output cal_ctl_t         ctl,
  output logic [LAT_W-1:0] latency,
  output logic             calibrated,
  output logic             timeoutErr,
  output logic             gapErr
);
  localparam logic [LAT_W-1:0] CNT_LAST = LAT_W'(MAX_LAT);
  localparam logic [LAT_W-1:0] CNT_ONE  = LAT_W'(1);

  cal_state_t       state;
  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] latReg;
  logic             calHit;

  // The measurement ends in the same cycle the first word returns
  always_comb begin
    calHit        = (state == ST_COUNT) && dataValid;
    ctl.tapIdx    = (state == ST_RUN) ? latReg : cnt;
    ctl.tapEnable = (state == ST_RUN) || calHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      latReg     <= '0;
      timeoutErr <= 1'b0;
      gapErr     <= 1'b0;
    end else if (startPulse) begin
      state      <= ST_ARMED;
      cnt        <= '0;
      latReg     <= '0;
      timeoutErr <= 1'b0;
      gapErr     <= 1'b0;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (addrValid) begin
            state <= ST_COUNT;
            cnt   <= CNT_ONE;
          end
        end
        ST_COUNT: begin
          if (dataValid) begin
            latReg <= cnt;
            state  <= ST_RUN;
          end else if (cnt == CNT_LAST) begin
            timeoutErr <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
        end
        ST_RUN: begin
          if (tapValid && !dataValid) gapErr <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign latency    = latReg;
  assign calibrated = (state == ST_RUN);
endmodule

// File: rtl/lat_cal_datapath.sv
module lat_cal_datapath
  import lat_cal_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addrValid,
  input  logic [TAG_W-1:0] tagIn,
  input  cal_ctl_t         ctl,
  output logic             tapValid,
  output logic             tagOutValid,
  output logic [TAG_W-1:0] tagOut
);
  localparam int ENT_W = TAG_W + 1;

  // Entry i holds {valid, tag} delayed by i cycles; entry 0 is the live input
  logic [ENT_W-1:0] stage [TAPS];

  assign stage[0] = {addrValid, tagIn};

  for (genvar i = 1; i < TAPS; i++) begin : g_delay
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  logic [ENT_W-1:0] tapEntry;
  assign tapEntry    = stage[ctl.tapIdx];
  assign tapValid    = tapEntry[ENT_W-1];
  assign tagOut      = tapEntry[TAG_W-1:0];
  assign tagOutValid = tapValid && ctl.tapEnable;
endmodule

// File: rtl/rd_lat_calibrator.sv
module rd_lat_calibrator
  import lat_cal_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic             addrValid,
  input  logic [TAG_W-1:0] tagIn,
  input  logic             dataValid,
  output logic [LAT_W-1:0] latency,
  output logic             calibrated,
  output logic             timeoutErr,
  output logic             gapErr,
  output logic [TAG_W-1:0] tagOut,
  output logic             tagOutValid
);
  cal_ctl_t ctl;
  logic     tapValid;

  lat_cal_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .addrValid  (addrValid),
    .dataValid  (dataValid),
    .tapValid   (tapValid),
    .ctl        (ctl),
    .latency    (latency),
    .calibrated (calibrated),
    .timeoutErr (timeoutErr),
    .gapErr     (gapErr)
  );

  lat_cal_datapath #(.TAG_W(TAG_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .addrValid   (addrValid),
    .tagIn       (tagIn),
    .ctl         (ctl),
    .tapValid    (tapValid),
    .tagOutValid (tagOutValid),
    .tagOut      (tagOut)
  );
endmodule

// File: rtl/rd_lat_calibrator_chk.sv
module rd_lat_calibrator_chk
  import lat_cal_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             startPulse,
  input logic             dataValid,
  input logic [LAT_W-1:0] latency,
  input logic             calibrated,
  input logic             timeoutErr,
  input logic             gapErr,
  input logic             tagOutValid
);
  assert_cal_after_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calibrated) |-> $past(dataValid));

  assert_latency_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    calibrated && !startPulse |=> $stable(latency));

  assert_latency_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    calibrated |-> latency != '0);

  assert_timeout_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(timeoutErr && calibrated));

  assert_gap_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gapErr && !startPulse |=> gapErr);

  assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    startPulse |=> !calibrated && !gapErr && !timeoutErr && latency == '0);

  assert_out_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tagOutValid |-> (calibrated || dataValid));
endmodule

bind rd_lat_calibrator rd_lat_calibrator_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .startPulse  (startPulse),
  .dataValid   (dataValid),
  .latency     (latency),
  .calibrated  (calibrated),
  .timeoutErr  (timeoutErr),
  .gapErr      (gapErr),
  .tagOutValid (tagOutValid)
);

// File: tb/test_rd_lat_calibrator.sv
module test_rd_lat_calibrator;
  localparam int TAG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startPulse = 1'b0;
  logic             addrValid = 1'b0;
  logic [TAG_W-1:0] tagIn = '0;
  logic             dataValid = 1'b0;
  logic [3:0]       latency;
  logic             calibrated, timeoutErr, gapErr, tagOutValid;
  logic [TAG_W-1:0] tagOut;

  always #5 clk = ~clk;

  rd_lat_calibrator #(.TAG_W(TAG_W)) i_rd_lat_calibrator (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .addrValid(addrValid),
    .tagIn(tagIn), .dataValid(dataValid), .latency(latency),
    .calibrated(calibrated), .timeoutErr(timeoutErr), .gapErr(gapErr),
    .tagOut(tagOut), .tagOutValid(tagOutValid)
  );

  typedef struct { int due; logic [TAG_W-1:0] tag; } exp_t;
  exp_t expQ[$];

  int checks = 0;
  int errors = 0;
  int tickNo = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp_v);
    checks = checks + 1;
    if (act != exp_v) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp_v, tickNo);
    end
  endtask

  // Monitor: compare aligned tags against the scoreboard, before the edge
  task automatic monitor();
    if (tagOutValid) begin
      if (expQ.size() == 0) begin
        chk("R5 unexpected tagOutValid", 1, 0);
      end else begin
        chk("R5 tag due cycle", tickNo, expQ[0].due);
        chk("R5 tag value", int'(tagOut), int'(expQ[0].tag));
        void'(expQ.pop_front());
      end
    end else if (expQ.size() != 0 && expQ[0].due == tickNo) begin
      chk("R5 missing tagOutValid", 0, 1);
      void'(expQ.pop_front());
    end
  endtask

  // Driver: one cycle of stimulus; returns just after the closing edge
  task automatic tick(input logic av, input logic dv, input logic [TAG_W-1:0] tg,
                      input logic st, input int lat);
    startPulse = st;
    addrValid  = av;
    dataValid  = dv;
    tagIn      = tg;
    if (av && lat > 0) expQ.push_back('{due: tickNo + lat, tag: tg});
    #1;
    monitor();
    @(negedge clk);
    tickNo = tickNo + 1;
  endtask

  task automatic doStart();
    expQ.delete();
    tick(1'b1, 1'b0, 8'hEE, 1'b1, 0);  // address in the start cycle is not counted
    chk("R7 calibrated cleared", int'(calibrated), 0);
    chk("R7 latency cleared", int'(latency), 0);
    chk("R7 gapErr cleared", int'(gapErr), 0);
    chk("R7 timeoutErr cleared", int'(timeoutErr), 0);
  endtask

  // One calibration run: n addresses from cycle 0, words back after lat cycles
  task automatic runCal(input int lat, input int n, input int gapAt, input bit noise);
    doStart();
    if (noise) begin
      tick(1'b0, 1'b1, '0, 1'b0, 0);
      tick(1'b0, 1'b1, '0, 1'b0, 0);
    end
    for (int i = 0; i < n + lat + 3; i++) begin
      logic av, dv;
      av = (i < n);
      dv = (i >= lat) && (i < lat + n) && (i != gapAt);
      tick(av, dv, TAG_W'(lat * 16 + i), 1'b0, lat);
      if (i == lat - 1) chk("R3 not yet calibrated", int'(calibrated), 0);
      if (i == lat) begin
        chk("R3 calibrated after hit", int'(calibrated), 1);
        chk(noise ? "R8 latency despite early valid" : "R2 measured latency",
            int'(latency), lat);
      end
      if (gapAt >= 0 && i == gapAt - 1) chk("R6 no gap yet", int'(gapErr), 0);
      if (gapAt >= 0 && i == gapAt) chk("R6 gap flagged", int'(gapErr), 1);
    end
    chk("R3 latency held", int'(latency), lat);
    chk("R6 gap state at end", int'(gapErr), (gapAt >= 0) ? 1 : 0);
    chk("R5 scoreboard drained", expQ.size(), 0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 calibrated", int'(calibrated), 0);
    chk("R1 latency", int'(latency), 0);
    chk("R1 tagOutValid", int'(tagOutValid), 0);
    rst_n = 1'b1;
    // Idle before first start: address and valid do nothing
    tick(1'b1, 1'b0, 8'h11, 1'b0, 0);
    tick(1'b0, 1'b1, 8'h00, 1'b0, 0);
    chk("R1 idle stays uncalibrated", int'(calibrated), 0);
    chk("R1 idle timeoutErr", int'(timeoutErr), 0);

    for (int lat = 1; lat <= 15; lat++) runCal(lat, 8, lat + 3, 1'b0);
    runCal(6, 10, -1, 1'b0);
    runCal(4, 5, -1, 1'b1);

    // Timeout: one address, nothing returns
    doStart();
    for (int i = 0; i < 20; i++) begin
      tick(i == 0, i == 17, 8'h55, 1'b0, 0);
      if (i == 14) chk("R4 no timeout at 14", int'(timeoutErr), 0);
      if (i == 15) chk("R4 timeout after 15", int'(timeoutErr), 1);
    end
    chk("R4 late valid not calibrated", int'(calibrated), 0);
    chk("R4 latency unknown", int'(latency), 0);

    // Restart after a timeout calibrates again
    runCal(2, 4, -1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule